// File: doc/BRIEF.md
# Programmable Logic Macrocell

This block is one output cell of a small programmable-logic fabric. It takes five product terms from an AND array that sits outside it. It also takes two sum contributions from the cells above and below it, and the chip-wide clock, set/reset and enable lines. Static configuration inputs decide four things: what each product term is used for, whether the storage element behaves as a D or a T flip-flop, whether that element is bypassed, and where the clock, set/reset and output enable come from. The cell drives a pad value and a pad enable. It also drives a feedback copy for the interconnect and the product terms it hands on to its neighbours.

The cell is built for emulation inside a synchronous fabric. A fabric clock `clk` samples everything. The clock line chosen for the cell is edge-detected between two consecutive samples, and its rising edge acts as a clock enable. Set and clear are level overrides that take effect at the next fabric edge. Every output is registered, so each output shows the effect of the inputs sampled at the previous `clk` edge.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst` is high, at every `clk` edge the storage element, `pad_o`, `pad_oe_o`, `fb_o` and all of `fwd_o` are cleared to 0.
- R2: Each product term has a 2-bit use code in `cfg_use_i[2i+1:2i]`: 0 = special, 1 = sum, 2 = forward, 3 = off. The OR sum is the OR of the terms coded 1 and of `nb_up_i` and `nb_dn_i`. Terms with any other code contribute 0 to it.
- R3: `fwd_o[i]` equals `pt_i[i]` one cycle later when term i is coded 2, and is 0 otherwise.
- R4: The cell value x is the OR sum XOR term 0. Term 0 counts only when it is coded special; otherwise that operand is 0.
- R5: With `cfg_tmode_i`=0, the storage element loads x when the selected clock line rose between the previous and the current `clk` sample. It holds its value when there is no such edge.
- R6: With `cfg_tmode_i`=1, the storage element inverts on a selected-clock rising edge when x=1 and holds when x=0.
- R7: `cfg_clk_sel_i` values 0..2 select `gclk_i[0..2]`. Value 3 selects product term 1, which counts only when coded special. A global clock that is not selected has no effect.
- R8: The element is set by term 2 (coded special) or by `gsr_i` when `cfg_gsr_en_i`=1 and `cfg_gsr_set_i`=1. It is cleared by term 3 (coded special) or by `gsr_i` when `cfg_gsr_en_i`=1 and `cfg_gsr_set_i`=0. Set wins over clear, and both win over a clock edge.
- R9: With `cfg_bypass_i`=1, `fb_o` equals x one cycle later, whatever the clock.
- R10: `cfg_oe_sel_i`=0 selects product term 4 as the enable, counting only when coded special. Values 1..2 select `goe_i[0..1]`. `pad_oe_o` carries the selected enable, and `pad_o` is the cell value when enabled and 0 otherwise.
- R11: `fb_o` carries the cell value, meaning the element state or x when bypassed, whatever the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_i | input | 5 | Local product terms |
| nb_up_i | input | 1 | Sum contribution from the upper neighbour |
| nb_dn_i | input | 1 | Sum contribution from the lower neighbour |
| gclk_i | input | NUM_GCLK | Global clock lines |
| gsr_i | input | 1 | Global set/reset line |
| goe_i | input | NUM_GOE | Global output-enable lines |
| cfg_use_i | input | 10 | Per-term use codes, two bits per term |
| cfg_tmode_i | input | 1 | 1 = T behaviour, 0 = D behaviour |
| cfg_bypass_i | input | 1 | 1 = combinational value drives the outputs |
| cfg_clk_sel_i | input | clog2(NUM_GCLK+1) | Clock source select |
| cfg_oe_sel_i | input | clog2(NUM_GOE+1) | Output-enable source select |
| cfg_gsr_en_i | input | 1 | Global set/reset line is used |
| cfg_gsr_set_i | input | 1 | Global line sets (1) or clears (0) |
| pad_o | output | 1 | Pad data, gated by the enable |
| pad_oe_o | output | 1 | Pad enable |
| fb_o | output | 1 | Feedback copy of the cell value |
| fwd_o | output | 5 | Product terms handed on to neighbours |

## Verification
On every cycle, the assertions check the storage element's override order (set beats clear, both beat the clock), T-mode hold on a zero operand, and hold when no edge arrives. They also check that forwarded terms stay quiet unless claimed, that the pad data is gated by its enable, and that the bypass path follows x. Other behaviours show only in the bench's scenarios: the exact OR/XOR values for mixed use codes, which clock source is actually selected, T-mode toggling across several edges, and the choice between global and product-term enables.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Number of product terms owned by one cell; special functions sit at fixed slots.
  localparam int MC_NUM_PT = 5;

  localparam int SLOT_XOR = 0;
  localparam int SLOT_CLK = 1;
  localparam int SLOT_SET = 2;
  localparam int SLOT_CLR = 3;
  localparam int SLOT_OE  = 4;

  typedef enum logic [1:0] {
    USE_SPECIAL = 2'd0,
    USE_SUM     = 2'd1,
    USE_FWD     = 2'd2,
    USE_OFF     = 2'd3
  } pt_use_e;

endpackage

// File: rtl/mc_pterm_steer.sv
module mc_pterm_steer #(
  parameter int NUM_PT = mc_pkg::MC_NUM_PT
) (
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic [2*NUM_PT-1:0] use_i,
  input  logic                nb_up_i,
  input  logic                nb_dn_i,
  output logic                x_o,
  output logic                pt_clk_o,
  output logic                pt_set_o,
  output logic                pt_clr_o,
  output logic                pt_oe_o,
  output logic [NUM_PT-1:0]   fwd_o
);
  import mc_pkg::*;

  logic [NUM_PT-1:0] to_sum;
  logic [NUM_PT-1:0] to_spec;
  logic              sum_w;

  // Each term goes to exactly one destination, chosen by its own code.
  for (genvar g = 0; g < NUM_PT; g++) begin : g_term
    pt_use_e use_g;
    assign use_g      = pt_use_e'(use_i[2*g +: 2]);
    assign to_sum[g]  = pt_i[g] & (use_g == USE_SUM);
    assign to_spec[g] = pt_i[g] & (use_g == USE_SPECIAL);
    assign fwd_o[g]   = pt_i[g] & (use_g == USE_FWD);
  end

  assign sum_w    = (|to_sum) | nb_up_i | nb_dn_i;
  assign x_o      = sum_w ^ to_spec[SLOT_XOR];
  assign pt_clk_o = to_spec[SLOT_CLK];
  assign pt_set_o = to_spec[SLOT_SET];
  assign pt_clr_o = to_spec[SLOT_CLR];
  assign pt_oe_o  = to_spec[SLOT_OE];

endmodule

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel #(
  parameter int NUM_GCLK = 3,
  parameter int NUM_GOE  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_GCLK-1:0]                gclk_i,
  input  logic                               gsr_i,
  input  logic [NUM_GOE-1:0]                 goe_i,
  input  logic                               pt_clk_i,
  input  logic                               pt_set_i,
  input  logic                               pt_clr_i,
  input  logic                               pt_oe_i,
  input  logic [$clog2(NUM_GCLK+1)-1:0]      clk_sel_i,
  input  logic [$clog2(NUM_GOE+1)-1:0]       oe_sel_i,
  input  logic                               gsr_en_i,
  input  logic                               gsr_set_i,
  output logic                               edge_o,
  output logic                               set_o,
  output logic                               clr_o,
  output logic                               oe_o
);
  localparam int CSW = $clog2(NUM_GCLK + 1);
  localparam int OSW = $clog2(NUM_GOE + 1);

  logic cs_w;
  logic cs_q;

  // Clock source: globals by index, the top code picks the product-term clock.
  always_comb begin
    cs_w = 1'b0;
    if (clk_sel_i == CSW'(NUM_GCLK)) begin
      cs_w = pt_clk_i;
    end else begin
      for (int i = 0; i < NUM_GCLK; i++) begin
        if (clk_sel_i == CSW'(i)) cs_w = gclk_i[i];
      end
    end
  end

  // Previous sample of the chosen line; reset to 1 so no edge is seen out of reset.
  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_w;
  end

  assign edge_o = cs_w & ~cs_q;

  assign set_o = pt_set_i | (gsr_en_i & gsr_set_i & gsr_i);
  assign clr_o = pt_clr_i | (gsr_en_i & ~gsr_set_i & gsr_i);

  // Enable source: code 0 is the product term, 1..NUM_GOE the global lines.
  always_comb begin
    oe_o = 1'b0;
    if (oe_sel_i == '0) begin
      oe_o = pt_oe_i;
    end else begin
      for (int i = 0; i < NUM_GOE; i++) begin
        if (oe_sel_i == OSW'(i + 1)) oe_o = goe_i[i];
      end
    end
  end

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic tmode_i,
  input  logic d_i,
  output logic q_o,
  output logic q_nxt_o
);

  // Override order: set, then clear, then the clock edge.
  always_comb begin
    if (set_i)       q_nxt_o = 1'b1;
    else if (clr_i)  q_nxt_o = 1'b0;
    else if (edge_i) q_nxt_o = tmode_i ? (q_o ^ d_i) : d_i;
    else             q_nxt_o = q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= q_nxt_o;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);

  assert_t_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tmode_i && !d_i && !set_i && !clr_i) |=> $stable(q_o));

  assert_no_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!edge_i && !set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int NUM_GCLK = 3,
  parameter int NUM_GOE  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [mc_pkg::MC_NUM_PT-1:0]       pt_i,
  input  logic                               nb_up_i,
  input  logic                               nb_dn_i,
  input  logic [NUM_GCLK-1:0]                gclk_i,
  input  logic                               gsr_i,
  input  logic [NUM_GOE-1:0]                 goe_i,
  input  logic [2*mc_pkg::MC_NUM_PT-1:0]     cfg_use_i,
  input  logic                               cfg_tmode_i,
  input  logic                               cfg_bypass_i,
  input  logic [$clog2(NUM_GCLK+1)-1:0]      cfg_clk_sel_i,
  input  logic [$clog2(NUM_GOE+1)-1:0]       cfg_oe_sel_i,
  input  logic                               cfg_gsr_en_i,
  input  logic                               cfg_gsr_set_i,
  output logic                               pad_o,
  output logic                               pad_oe_o,
  output logic                               fb_o,
  output logic [mc_pkg::MC_NUM_PT-1:0]       fwd_o
);
  import mc_pkg::*;

  localparam int NUM_PT = MC_NUM_PT;

  logic              x_w;
  logic              pt_clk_w, pt_set_w, pt_clr_w, pt_oe_w;
  logic [NUM_PT-1:0] fwd_w;
  logic              edge_w, set_w, clr_w, oe_w;
  logic              q_w, q_nxt_w;
  logic              val_w;

  mc_pterm_steer #(.NUM_PT(NUM_PT)) u_steer (
    .pt_i     (pt_i),
    .use_i    (cfg_use_i),
    .nb_up_i  (nb_up_i),
    .nb_dn_i  (nb_dn_i),
    .x_o      (x_w),
    .pt_clk_o (pt_clk_w),
    .pt_set_o (pt_set_w),
    .pt_clr_o (pt_clr_w),
    .pt_oe_o  (pt_oe_w),
    .fwd_o    (fwd_w)
  );

  mc_ctrl_sel #(.NUM_GCLK(NUM_GCLK), .NUM_GOE(NUM_GOE)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .gclk_i    (gclk_i),
    .gsr_i     (gsr_i),
    .goe_i     (goe_i),
    .pt_clk_i  (pt_clk_w),
    .pt_set_i  (pt_set_w),
    .pt_clr_i  (pt_clr_w),
    .pt_oe_i   (pt_oe_w),
    .clk_sel_i (cfg_clk_sel_i),
    .oe_sel_i  (cfg_oe_sel_i),
    .gsr_en_i  (cfg_gsr_en_i),
    .gsr_set_i (cfg_gsr_set_i),
    .edge_o    (edge_w),
    .set_o     (set_w),
    .clr_o     (clr_w),
    .oe_o      (oe_w)
  );

  mc_store u_store (
    .clk     (clk),
    .rst     (rst),
    .edge_i  (edge_w),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .tmode_i (cfg_tmode_i),
    .d_i     (x_w),
    .q_o     (q_w),
    .q_nxt_o (q_nxt_w)
  );

  // The outputs show the state after the current edge, or x when bypassed.
  assign val_w = cfg_bypass_i ? x_w : q_nxt_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o    <= 1'b0;
      pad_oe_o <= 1'b0;
      fb_o     <= 1'b0;
      fwd_o    <= '0;
    end else begin
      pad_o    <= oe_w & val_w;
      pad_oe_o <= oe_w;
      fb_o     <= val_w;
      fwd_o    <= fwd_w;
    end
  end

  for (genvar g = 0; g < NUM_PT; g++) begin : g_fwd_chk
    assert_fwd_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (cfg_use_i[2*g +: 2] != USE_FWD) |=> !fwd_o[g]);
  end

  assert_pad_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !pad_oe_o |-> !pad_o);

  assert_fb_pad_R11: assert property (@(posedge clk) disable iff (rst)
    pad_oe_o |-> (pad_o == fb_o));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass_i |=> (fb_o == $past(x_w)));

  // Guard against a state word left unused by the bypass mux.
  logic unused_q;
  assign unused_q = q_w;

endmodule

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] pt = '0;
  logic       up = 1'b0, dn = 1'b0;
  logic [2:0] gclk = '0;
  logic       gsr = 1'b0;
  logic [1:0] goe = '0;
  logic [9:0] use_c = 10'h155;
  logic       tmode = 1'b0, bypass = 1'b0;
  logic [1:0] csel = '0, osel = 2'd1;
  logic       gsr_en = 1'b0, gsr_set = 1'b0;
  logic       pad, pad_oe, fb;
  logic [4:0] fwd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_macrocell u0 (
    .clk(clk), .rst(rst), .pt_i(pt), .nb_up_i(up), .nb_dn_i(dn),
    .gclk_i(gclk), .gsr_i(gsr), .goe_i(goe), .cfg_use_i(use_c),
    .cfg_tmode_i(tmode), .cfg_bypass_i(bypass), .cfg_clk_sel_i(csel),
    .cfg_oe_sel_i(osel), .cfg_gsr_en_i(gsr_en), .cfg_gsr_set_i(gsr_set),
    .pad_o(pad), .pad_oe_o(pad_oe), .fb_o(fb), .fwd_o(fwd)
  );

  // {use[9:0], pt[4:0], up, dn, expected value, expected fwd[4:0]}
  localparam logic [22:0] VEC [10] = '{
    {10'h155, 5'b00000, 1'b0, 1'b0, 1'b0, 5'b00000},
    {10'h155, 5'b00100, 1'b0, 1'b0, 1'b1, 5'b00000},
    {10'h2AA, 5'b11111, 1'b0, 1'b0, 1'b0, 5'b11111},
    {10'h2AA, 5'b00000, 1'b1, 1'b0, 1'b1, 5'b00000},
    {10'h154, 5'b00001, 1'b0, 1'b0, 1'b1, 5'b00000},
    {10'h154, 5'b00011, 1'b0, 1'b0, 1'b0, 5'b00000},
    {10'h154, 5'b00001, 1'b0, 1'b1, 1'b0, 5'b00000},
    {10'h3FF, 5'b11111, 1'b0, 1'b0, 1'b0, 5'b00000},
    {10'h266, 5'b10101, 1'b0, 1'b0, 1'b0, 5'b10101},
    {10'h266, 5'b01010, 1'b0, 1'b0, 1'b1, 5'b00000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    rst = 1'b1;
    step();
    chk("R1 fb", {7'd0, fb}, 8'd0);
    chk("R1 pad", {6'd0, pad, pad_oe}, 8'd0);
    chk("R1 fwd", {3'd0, fwd}, 8'd0);
    rst = 1'b0;

    // Table walk: bypass, global enable 0 on, combinational value checks (R2 R3 R4 R9).
    bypass = 1'b1; osel = 2'd1; goe = 2'b01;
    for (int k = 0; k < 10; k++) begin
      use_c = VEC[k][22:13];
      pt    = VEC[k][12:8];
      up    = VEC[k][7];
      dn    = VEC[k][6];
      step();
      chk($sformatf("R2_R4_R9 fb vec%0d", k), {7'd0, fb}, {7'd0, VEC[k][5]});
      chk($sformatf("R10 pad vec%0d", k), {7'd0, pad}, {7'd0, VEC[k][5]});
      chk($sformatf("R3 fwd vec%0d", k), {3'd0, fwd}, {3'd0, VEC[k][4:0]});
    end
    up = 1'b0; dn = 1'b0;

    // R5: D behaviour on global clock 0.
    do_reset();
    bypass = 1'b0; tmode = 1'b0; csel = 2'd0; use_c = 10'h155;
    pt = 5'b00001; gclk = 3'b000;
    step(); chk("R5 no edge", {7'd0, fb}, 8'd0);
    gclk = 3'b001;
    step(); chk("R5 load 1", {7'd0, fb}, 8'd1);
    pt = 5'b00000;
    step(); chk("R5 high no edge", {7'd0, fb}, 8'd1);
    gclk = 3'b010;
    step(); chk("R7 unselected clk", {7'd0, fb}, 8'd1);
    gclk = 3'b001;
    step(); chk("R5 load 0", {7'd0, fb}, 8'd0);

    // R6: T behaviour.
    do_reset();
    tmode = 1'b1; pt = 5'b00001; gclk = 3'b000;
    step();
    gclk = 3'b001; step(); chk("R6 toggle 1", {7'd0, fb}, 8'd1);
    gclk = 3'b000; step(); chk("R6 hold low clk", {7'd0, fb}, 8'd1);
    gclk = 3'b001; step(); chk("R6 toggle 0", {7'd0, fb}, 8'd0);
    gclk = 3'b000; step();
    gclk = 3'b001; step(); chk("R6 toggle 1 again", {7'd0, fb}, 8'd1);
    pt = 5'b00000;
    gclk = 3'b000; step();
    gclk = 3'b001; step(); chk("R6 hold on x0", {7'd0, fb}, 8'd1);
    tmode = 1'b0;

    // R7: product-term clock (term 1 special).
    do_reset();
    csel = 2'd3; use_c = 10'h151; pt = 5'b00100; gclk = 3'b000;
    step(); chk("R7 pt clk idle", {7'd0, fb}, 8'd0);
    gclk = 3'b111;
    step(); chk("R7 globals ignored", {7'd0, fb}, 8'd0);
    pt = 5'b00110;
    step(); chk("R7 pt clk edge", {7'd0, fb}, 8'd1);

    // R8: set / clear by product terms and by the global line.
    do_reset();
    csel = 2'd0; use_c = 10'h105; gclk = 3'b000;
    pt = 5'b00100; step(); chk("R8 pt set", {7'd0, fb}, 8'd1);
    pt = 5'b00000; step(); chk("R8 set release hold", {7'd0, fb}, 8'd1);
    pt = 5'b01100; step(); chk("R8 set wins", {7'd0, fb}, 8'd1);
    pt = 5'b01000; step(); chk("R8 pt clear", {7'd0, fb}, 8'd0);
    pt = 5'b00000; up = 1'b1; step();
    pt = 5'b01000; gclk = 3'b001; step(); chk("R8 clear beats edge", {7'd0, fb}, 8'd0);
    pt = 5'b00000; step(); chk("R8 no second edge", {7'd0, fb}, 8'd0);
    up = 1'b0; gsr_en = 1'b1; gsr_set = 1'b1; gsr = 1'b1;
    step(); chk("R8 global set", {7'd0, fb}, 8'd1);
    gsr_set = 1'b0;
    step(); chk("R8 global clear", {7'd0, fb}, 8'd0);
    gsr_en = 1'b0; gsr = 1'b0; gclk = 3'b000;

    // R10 / R11: enable sources and feedback independence.
    do_reset();
    bypass = 1'b1; use_c = 10'h055; osel = 2'd0; pt = 5'b00001;
    step();
    chk("R10 pt oe off", {6'd0, pad_oe, pad}, 8'd0);
    chk("R11 fb when disabled", {7'd0, fb}, 8'd1);
    pt = 5'b10001; step();
    chk("R10 pt oe on", {6'd0, pad_oe, pad}, 8'd3);
    pt = 5'b00001; osel = 2'd2; goe = 2'b10; step();
    chk("R10 goe1 on", {6'd0, pad_oe, pad}, 8'd3);
    goe = 2'b01; step();
    chk("R10 goe1 off", {6'd0, pad_oe, pad}, 8'd0);
    chk("R11 fb goe off", {7'd0, fb}, 8'd1);

    summary();
  end

endmodule